// File: doc/BRIEF.md
# Quadrature Phase-Slope Frequency Estimator

This block measures the frequency of an oscillator that provides both a sine and a cosine output. The two outputs are digitised at the same moment, and each pair arrives as one sample with a valid strobe. The block turns each pair into an angle on a fixed-point circle. It finds the angle from a small arctangent table that covers one octant, and mirrors the result into the correct part of the circle. A turn counter sits above the angle bits, so the phase keeps growing across the point where the angle wraps. Each phase value is subtracted from the phase a fixed number of samples earlier. That difference is then averaged by a single-stage comb-integrator filter.

The output is a signed sum of phase increments over a window, which is proportional to the oscillator frequency. It comes with a valid strobe that rises once the delay line and the averaging window hold real data. A pair with both words equal to zero has no defined angle. In that case the previous angle is reused and a one-cycle flag is raised.

Top module: `quad_phase_freq_est`

## Requirements
- R1: The angle is atan2(sine, cosine) as an unsigned fraction of a turn in 2^ANG_W steps (4096 by default). Positive cosine on the axis maps to 0, positive sine to 1024, negative cosine to 2048 and negative sine to 3072. Equal magnitudes map to 512, 1536, 2560 and 3584 in the four quadrants. A zero word counts as non-negative.
- R2: Let r = floor(64·min(|sin|,|cos|)/max(|sin|,|cos|)) and a = round(atan(r/64)·4096/2π). The angle is then built from a as follows. With sin ≥ 0 and cos ≥ 0 it is a, or 1024−a when |sin| > |cos|. With sin ≥ 0 and cos < 0 it is 2048−a, or 1024+a when |sin| > |cos|. With both negative it is 2048+a, or 3072−a when |sin| > |cos|. With sin < 0 and cos ≥ 0 it is (4096−a) mod 4096, or 3072+a when |sin| > |cos|.
- R3: The phase is {turn, angle}. The turn count rises by one when the angle falls by more than half a turn between samples, and drops by one when it rises by more than half a turn. A rotation that passes through zero in either direction therefore gives a steady output. Rotating by +512 per sample gives +16384, and rotating by −512 per sample gives −16384.
- R4: Each phase is differenced against the phase exactly DLY_N = 8 accepted samples earlier.
- R5: For accepted sample k, the output equals the sum over j = 0..CIC_M−1 (CIC_M = 4) of P[k−j] − P[k−j−8], where P is the unwrapped phase.
- R6: A pair with both words zero keeps the previous angle, which adds a zero increment. null_o is high for exactly one cycle, after the second rising edge that follows the edge accepting that pair.
- R7: After reset, freq_valid_o stays low for the first DLY_N+CIC_M−1 = 11 accepted samples. The 12th sample produces the first output.
- R8: One output is produced per accepted sample, including back-to-back samples. freq_valid_o rises after the sixth rising edge counted from, and including, the edge that accepts the sample.
- R9: In reset, freq_valid_o, null_o and freq_o are all zero.
- R10: freq_o does not change while freq_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid_i | input | 1 | Sample pair valid |
| sin_i | input | ADC_W (10) | Signed sine word |
| cos_i | input | ADC_W (10) | Signed cosine word |
| freq_valid_o | output | 1 | Output sum valid |
| freq_o | output | OUT_W (22) | Signed windowed sum of N-sample phase differences |
| null_o | output | 1 | One-cycle flag for an all-zero pair |

## Verification
The hardest case to reach from the ports is a phase that runs backwards through the zero angle. In that case the turn counter has to decrement rather than increment. Directed runs step around the eight axis and diagonal points in both directions, so that both wrap directions cross zero many times inside one delay window. A table of irregular pairs then mixes large and small steps, all-zero pairs, full-scale negative words and near-diagonal ratios. It is checked against a phase model that follows the stated angle and unwrap rules.

// File: rtl/qpe_pkg.sv
package qpe_pkg;

    typedef struct packed {
        logic valid;
        logic zero;
        logic neg_x;
        logic neg_y;
        logic swap;
    } fold_flags_t;

    typedef enum logic [1:0] {
        WRAP_NONE,
        WRAP_UP,
        WRAP_DOWN
    } wrap_e;

    // first-octant angle for ratio index r out of lut_n, in 'steps' per turn
    function automatic int oct_angle(int r, int lut_n, int steps);
        real x;
        real t;
        x = real'(r) / real'(lut_n);
        t = $atan(x) * real'(steps) / (2.0 * 3.14159265358979);
        return $rtoi(t + 0.5);
    endfunction

    function automatic int ratio_idx(int mn, int mx, int lut_n);
        if (mx == 0) return 0;
        return (mn * lut_n) / mx;
    endfunction

    // mirror a first-octant angle into the full circle
    function automatic int rebuild(int a, logic nx, logic ny, logic sw, int steps);
        int qt;
        int r;
        qt = steps / 4;
        case ({nx, ny})
            2'b00:   r = sw ? (qt - a)     : a;
            2'b10:   r = sw ? (qt + a)     : (2 * qt - a);
            2'b11:   r = sw ? (3 * qt - a) : (2 * qt + a);
            default: r = sw ? (3 * qt + a) : (steps - a);
        endcase
        return r % steps;
    endfunction

endpackage

// File: rtl/qpe_angle.sv
module qpe_angle #(
    parameter int ADC_W  = 10,
    parameter int ANG_W  = 12,
    parameter int LUT_AW = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic signed [ADC_W-1:0] sin_i,
    input  logic signed [ADC_W-1:0] cos_i,
    output logic                    out_valid,
    output logic                    out_zero,
    output logic [ANG_W-1:0]        ang_o
);
    import qpe_pkg::*;

    localparam int LUT_N = 1 << LUT_AW;
    localparam int IDX_W = LUT_AW + 1;
    localparam int ROM_D = 1 << IDX_W;
    localparam int STEPS = 1 << ANG_W;

    // computed first-octant table, upper unused half tied to zero
    logic [ANG_W-1:0] rom [ROM_D];
    for (genvar g = 0; g < ROM_D; g++) begin : g_rom
        localparam int GV = (g > LUT_N) ? 0 : oct_angle(g, LUT_N, STEPS);
        assign rom[g] = ANG_W'(GV);
    end

    // stage 1: fold into the first octant
    logic [ADC_W-1:0] mag_x, mag_y;
    logic             y_gt_x;
    fold_flags_t      s1_f;
    logic [ADC_W-1:0] s1_min, s1_max;

    always_comb begin
        mag_x  = cos_i[ADC_W-1] ? ADC_W'(-cos_i) : ADC_W'(cos_i);
        mag_y  = sin_i[ADC_W-1] ? ADC_W'(-sin_i) : ADC_W'(sin_i);
        y_gt_x = mag_y > mag_x;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_f   <= '0;
            s1_min <= '0;
            s1_max <= '0;
        end else begin
            s1_f   <= '{valid: in_valid,
                        zero:  (mag_x == '0) && (mag_y == '0),
                        neg_x: cos_i[ADC_W-1],
                        neg_y: sin_i[ADC_W-1],
                        swap:  y_gt_x};
            s1_min <= y_gt_x ? mag_x : mag_y;
            s1_max <= y_gt_x ? mag_y : mag_x;
        end
    end

    // stage 2: lookup and rebuild, hold the angle on an all-zero pair
    logic [IDX_W-1:0] idx;
    logic [ANG_W-1:0] oct_a, ang_new;

    always_comb begin
        idx     = IDX_W'(ratio_idx(int'(s1_min), int'(s1_max), LUT_N));
        oct_a   = rom[idx];
        ang_new = ANG_W'(rebuild(int'(oct_a), s1_f.neg_x, s1_f.neg_y, s1_f.swap, STEPS));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_zero  <= 1'b0;
            ang_o     <= '0;
        end else begin
            out_valid <= s1_f.valid;
            out_zero  <= s1_f.valid && s1_f.zero;
            if (s1_f.valid && !s1_f.zero)
                ang_o <= ang_new;
        end
    end

endmodule

// File: rtl/qpe_unwrap.sv
module qpe_unwrap #(
    parameter int ANG_W  = 12,
    parameter int TURN_W = 8,
    parameter int FILL_N = 11
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [ANG_W-1:0]        ang_i,
    output logic                    ph_valid,
    output logic                    ph_ok,
    output logic [TURN_W+ANG_W-1:0] phase_o
);
    import qpe_pkg::*;

    localparam int CNT_W = $clog2(FILL_N + 1);
    localparam logic [ANG_W-1:0] HALF = ANG_W'(1 << (ANG_W - 1));

    logic [ANG_W-1:0]  prev_ang;
    logic [TURN_W-1:0] turn, turn_nx;
    logic [CNT_W-1:0]  seen;
    logic [ANG_W-1:0]  drop_gap, rise_gap;
    wrap_e             wk;

    always_comb begin
        drop_gap = prev_ang - ang_i;
        rise_gap = ang_i - prev_ang;
        if (ang_i < prev_ang && drop_gap > HALF)
            wk = WRAP_UP;
        else if (ang_i > prev_ang && rise_gap > HALF)
            wk = WRAP_DOWN;
        else
            wk = WRAP_NONE;
        case (wk)
            WRAP_UP:   turn_nx = turn + TURN_W'(1);
            WRAP_DOWN: turn_nx = turn - TURN_W'(1);
            default:   turn_nx = turn;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_ang <= '0;
            turn     <= '0;
            seen     <= '0;
            ph_valid <= 1'b0;
            ph_ok    <= 1'b0;
            phase_o  <= '0;
        end else begin
            ph_valid <= in_valid;
            if (in_valid) begin
                prev_ang <= ang_i;
                turn     <= turn_nx;
                phase_o  <= {turn_nx, ang_i};
                ph_ok    <= (seen == CNT_W'(FILL_N));
                if (seen != CNT_W'(FILL_N))
                    seen <= seen + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/qpe_slope.sv
module qpe_slope #(
    parameter int PH_W  = 20,
    parameter int DLY_N = 8,
    parameter int CIC_M = 4,
    parameter int OUT_W = 22
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ph_valid,
    input  logic                    ph_ok,
    input  logic [PH_W-1:0]         phase_i,
    output logic                    f_valid,
    output logic signed [OUT_W-1:0] freq_o
);
    // stage 4: delay line and N-sample difference
    logic [PH_W-1:0] dl [DLY_N];
    logic            d_v, d_ok;
    logic [PH_W-1:0] diff;

    for (genvar i = 0; i < DLY_N; i++) begin : g_dl
        always_ff @(posedge clk) begin
            if (rst)
                dl[i] <= '0;
            else if (ph_valid)
                dl[i] <= (i == 0) ? phase_i : dl[(i == 0) ? 0 : i - 1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            d_v  <= 1'b0;
            d_ok <= 1'b0;
            diff <= '0;
        end else begin
            d_v  <= ph_valid;
            d_ok <= ph_valid && ph_ok;
            if (ph_valid)
                diff <= phase_i - dl[DLY_N-1];
        end
    end

    // stage 5: integrator
    logic             a_v, a_ok;
    logic [OUT_W-1:0] acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_v  <= 1'b0;
            a_ok <= 1'b0;
            acc  <= '0;
        end else begin
            a_v  <= d_v;
            a_ok <= d_ok;
            if (d_v)
                acc <= acc + OUT_W'(signed'(diff));
        end
    end

    // stage 6: comb over CIC_M integrator values
    logic [OUT_W-1:0] hist [CIC_M];

    for (genvar j = 0; j < CIC_M; j++) begin : g_hist
        always_ff @(posedge clk) begin
            if (rst)
                hist[j] <= '0;
            else if (a_v)
                hist[j] <= (j == 0) ? acc : hist[(j == 0) ? 0 : j - 1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            f_valid <= 1'b0;
            freq_o  <= '0;
        end else begin
            f_valid <= a_v && a_ok;
            if (a_v && a_ok)
                freq_o <= signed'(acc - hist[CIC_M-1]);
        end
    end

endmodule

// File: rtl/quad_phase_freq_est.sv
module quad_phase_freq_est #(
    parameter int ADC_W  = 10,
    parameter int ANG_W  = 12,
    parameter int LUT_AW = 6,
    parameter int TURN_W = 8,
    parameter int DLY_N  = 8,
    parameter int CIC_M  = 4,
    localparam int PH_W  = TURN_W + ANG_W,
    localparam int OUT_W = PH_W + $clog2(CIC_M)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_valid_i,
    input  logic signed [ADC_W-1:0] sin_i,
    input  logic signed [ADC_W-1:0] cos_i,
    output logic                    freq_valid_o,
    output logic signed [OUT_W-1:0] freq_o,
    output logic                    null_o
);
    localparam int FILL_N = DLY_N + CIC_M - 1;

    logic             ang_v, ang_z;
    logic [ANG_W-1:0] ang;
    logic             ph_v, ph_ok;
    logic [PH_W-1:0]  phase;

    qpe_angle #(
        .ADC_W (ADC_W),
        .ANG_W (ANG_W),
        .LUT_AW(LUT_AW)
    ) u_angle (
        .clk      (clk),
        .rst      (rst),
        .in_valid (smp_valid_i),
        .sin_i    (sin_i),
        .cos_i    (cos_i),
        .out_valid(ang_v),
        .out_zero (ang_z),
        .ang_o    (ang)
    );

    assign null_o = ang_z;

    qpe_unwrap #(
        .ANG_W (ANG_W),
        .TURN_W(TURN_W),
        .FILL_N(FILL_N)
    ) u_unwrap (
        .clk     (clk),
        .rst     (rst),
        .in_valid(ang_v),
        .ang_i   (ang),
        .ph_valid(ph_v),
        .ph_ok   (ph_ok),
        .phase_o (phase)
    );

    qpe_slope #(
        .PH_W (PH_W),
        .DLY_N(DLY_N),
        .CIC_M(CIC_M),
        .OUT_W(OUT_W)
    ) u_slope (
        .clk     (clk),
        .rst     (rst),
        .ph_valid(ph_v),
        .ph_ok   (ph_ok),
        .phase_i (phase),
        .f_valid (freq_valid_o),
        .freq_o  (freq_o)
    );

endmodule

// File: rtl/qpe_freq_est_chk.sv
module qpe_freq_est_chk #(
    parameter int ADC_W = 10,
    parameter int DLY_N = 8,
    parameter int CIC_M = 4,
    parameter int OUT_W = 22
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    smp_valid_i,
    input logic signed [ADC_W-1:0] sin_i,
    input logic signed [ADC_W-1:0] cos_i,
    input logic                    freq_valid_o,
    input logic signed [OUT_W-1:0] freq_o,
    input logic                    null_o
);
    localparam int NEED  = DLY_N + CIC_M;
    localparam int SEEN_W = $clog2(NEED + 1);

    logic [SEEN_W-1:0] seen;
    logic              zero_in;

    assign zero_in = smp_valid_i && (sin_i == '0) && (cos_i == '0);

    always_ff @(posedge clk) begin
        if (rst)
            seen <= '0;
        else if (smp_valid_i && seen != SEEN_W'(NEED))
            seen <= seen + SEEN_W'(1);
    end

    p_out_from_sample_r8: assert property (@(posedge clk) disable iff (rst)
        freq_valid_o |-> $past(smp_valid_i, 6));

    p_fill_before_out_r7: assert property (@(posedge clk) disable iff (rst)
        freq_valid_o |-> (seen == SEEN_W'(NEED)));

    p_null_source_r6: assert property (@(posedge clk) disable iff (rst)
        null_o |-> $past(zero_in, 2));

    p_null_follows_r6: assert property (@(posedge clk) disable iff (rst)
        zero_in |-> ##2 null_o);

    p_hold_when_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !freq_valid_o |-> $stable(freq_o));

endmodule

bind quad_phase_freq_est qpe_freq_est_chk #(
    .ADC_W(ADC_W),
    .DLY_N(DLY_N),
    .CIC_M(CIC_M),
    .OUT_W(OUT_W)
) u_chk (.*);

// File: tb/tb_quad_phase_freq_est.sv
`timescale 1ns/1ps
module tb_quad_phase_freq_est;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               smp_valid_i = 1'b0;
    logic signed [9:0]  sin_i = '0;
    logic signed [9:0]  cos_i = '0;
    logic               freq_valid_o;
    logic signed [21:0] freq_o;
    logic               null_o;

    quad_phase_freq_est dut (
        .clk         (clk),
        .rst         (rst),
        .smp_valid_i (smp_valid_i),
        .sin_i       (sin_i),
        .cos_i       (cos_i),
        .freq_valid_o(freq_valid_o),
        .freq_o      (freq_o),
        .null_o      (null_o)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- reference model from the requirements ----------------
    int m_prev, m_phase, m_k;
    int m_ph [0:255];
    int exp_q[$];
    int got_q[$];
    bit mon_en = 1'b0;
    int null_cnt = 0;

    function automatic int exp_angle(input int x, input int y);
        int ax, ay, mn, mx, r, a;
        bit sw;
        ax = (x < 0) ? -x : x;
        ay = (y < 0) ? -y : y;
        sw = ay > ax;
        mn = sw ? ax : ay;
        mx = sw ? ay : ax;
        r  = (mn * 64) / mx;
        a  = $rtoi($atan(real'(r) / 64.0) * 4096.0 / (2.0 * 3.14159265358979) + 0.5);
        if (x >= 0 && y >= 0) return sw ? 1024 - a : a;
        if (x < 0 && y >= 0)  return sw ? 1024 + a : 2048 - a;
        if (x < 0 && y < 0)   return sw ? 3072 - a : 2048 + a;
        return sw ? 3072 + a : (4096 - a) % 4096;
    endfunction

    task automatic model_reset();
        m_prev = 0; m_phase = 0; m_k = 0;
        exp_q.delete(); got_q.delete(); null_cnt = 0;
    endtask

    task automatic model_push(input int x, input int y);
        int a, d, v;
        a = (x == 0 && y == 0) ? m_prev : exp_angle(x, y);
        d = a - m_prev;
        if (d < -2048) d += 4096;
        else if (d > 2048) d -= 4096;
        m_phase += d;
        m_ph[m_k] = m_phase;
        m_prev = a;
        if (m_k >= 11) begin
            v = 0;
            for (int j = 0; j < 4; j++) v += m_ph[m_k - j] - m_ph[m_k - j - 8];
            exp_q.push_back(v);
        end
        m_k++;
    endtask

    always @(negedge clk) begin
        if (mon_en && freq_valid_o) got_q.push_back(int'(freq_o));
        if (mon_en && null_o) null_cnt++;
    end

    // called at a falling edge; leaves at the next falling edge
    task automatic send(input int x, input int y);
        smp_valid_i = 1'b1;
        cos_i = 10'(x);
        sin_i = 10'(y);
        model_push(x, y);
        @(negedge clk);
        smp_valid_i = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        smp_valid_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    task automatic drain(input string tag);
        repeat (10) @(negedge clk);
        chk(got_q.size() == exp_q.size(), {tag, " output count"}, got_q.size(), exp_q.size());
        for (int k = 0; k < exp_q.size() && k < got_q.size(); k++)
            chk(got_q[k] == exp_q[k], tag, got_q[k], exp_q[k]);
        got_q.delete(); exp_q.delete();
    endtask

    function automatic int pt_x(input int k);
        case (k & 7)
            0: return 400;  1: return 300;  2: return 0;    3: return -300;
            4: return -400; 5: return -300; 6: return 0;    default: return 300;
        endcase
    endfunction
    function automatic int pt_y(input int k);
        case (k & 7)
            0: return 0;    1: return 300;  2: return 400;  3: return 300;
            4: return 0;    5: return -300; 6: return -400; default: return -300;
        endcase
    endfunction

    // ---------------- vector table: {cos, sin} ----------------
    localparam int NV = 40;
    localparam int VX [NV] = '{
        0,   400, 380, 300, 120, 0,   -150, -300, -350, -400,
        -350,-300,-150, 0,  150, 300, 350,  400,  200,  100,
        -100,-200,-200, 0,  0,  100, -512, 511,  1,    0,
        -512, 200, 300, 0,  -300,-400,-200, 100, 380,  400};
    localparam int VY [NV] = '{
        0,   0,   120, 300, 380, 400, 350,  300,  150,  0,
        -150,-300,-350,-400,-350,-300,-150, 0,    100,  200,
        200, 100, -100,0,   0,  -200, 0,    -512, 0,    -1,
        -512,-100,300, 400, 300, 0,   -100, -200, 120,  0};

    int n_zero;

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R8 watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : main
        int first_c;
        int hold_v;

        // R9: reset state
        do_reset();
        chk(freq_valid_o == 1'b0, "R9 freq_valid_o", int'(freq_valid_o), 0);
        chk(freq_o == '0, "R9 freq_o", int'(freq_o), 0);
        chk(null_o == 1'b0, "R9 null_o", int'(null_o), 0);
        mon_en = 1'b1;

        // table walk with occasional idle cycles
        n_zero = 0;
        for (int v = 0; v < NV; v++) begin
            if (VX[v] == 0 && VY[v] == 0) n_zero++;
            send(VX[v], VY[v]);
            if (v % 7 == 6) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        chk(null_cnt == n_zero, "R6 null pulse count", null_cnt, n_zero);
        drain("R2/R4/R5 table");

        // R7/R8: fill and latency, forward rotation
        do_reset();
        for (int k = 0; k < 11; k++) send(pt_x(k), pt_y(k));
        repeat (10) @(negedge clk);
        chk(got_q.size() == 0, "R7 no output before fill", got_q.size(), 0);
        smp_valid_i = 1'b1;
        cos_i = 10'(pt_x(11)); sin_i = 10'(pt_y(11));
        model_push(pt_x(11), pt_y(11));
        first_c = 0;
        for (int c = 1; c <= 8; c++) begin
            @(negedge clk);
            if (c == 1) smp_valid_i = 1'b0;
            if (freq_valid_o && first_c == 0) first_c = c;
        end
        chk(first_c == 6, "R8 latency in falling edges", first_c, 6);

        // R10: hold while idle
        hold_v = int'(freq_o);
        repeat (5) @(negedge clk);
        chk(int'(freq_o) == hold_v && !freq_valid_o, "R10 hold while idle", int'(freq_o), hold_v);

        // R1/R3: continue forward rotation across many wraps, back to back
        for (int k = 12; k < 36; k++) send(pt_x(k), pt_y(k));
        for (int k = 0; k < exp_q.size(); k++)
            chk(exp_q[k] == 16384, "R1 model forward step", exp_q[k], 16384);
        drain("R1/R3/R8 forward rotation");

        // R3: reverse rotation through zero
        do_reset();
        for (int k = 0; k < 24; k++) send(pt_x(64 - k), pt_y(64 - k));
        repeat (8) @(negedge clk);
        chk(got_q.size() == 13, "R3 reverse output count", got_q.size(), 13);
        for (int k = 0; k < got_q.size(); k++)
            chk(got_q[k] == -16384, "R3 reverse rotation", got_q[k], -16384);
        got_q.delete(); exp_q.delete();

        // R6: null timing and angle hold
        do_reset();
        for (int k = 0; k < 12; k++) send(pt_x(2), pt_y(2));
        smp_valid_i = 1'b1; cos_i = '0; sin_i = '0;
        model_push(0, 0);
        @(negedge clk);
        smp_valid_i = 1'b0;
        chk(null_o == 1'b0, "R6 null_o before", int'(null_o), 0);
        @(negedge clk);
        chk(null_o == 1'b1, "R6 null_o pulse", int'(null_o), 1);
        @(negedge clk);
        chk(null_o == 1'b0, "R6 null_o one cycle", int'(null_o), 0);
        for (int k = 0; k < 6; k++) send(0, 0);
        send(pt_x(2), pt_y(2));
        for (int k = 0; k < exp_q.size(); k++)
            chk(exp_q[k] == 0, "R6 model held angle", exp_q[k], 0);
        drain("R6 held angle output");

        mon_en = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule